// File: doc/BRIEF.md
# Multi-Word Register Transfer Sequencer

This block carries out the register-block transfer instructions of a processor core: one command moves a run of consecutive registers to or from memory as 32-bit words. The core supplies a starting register number, an already computed base byte address and a direction bit. The sequencer then issues one word access at a time on a request/ready memory port, and it uses a read port and a write port of the register file.

The number of words is not part of the command. Every transfer ends at the highest register (31), so a command that starts at register `s` moves `32 - s` words. A store sends the low 32 bits of each register. A load writes each returned word into its register with the upper 32 bits cleared. A base address that is not word aligned is refused with a one-cycle error pulse, and nothing is transferred.

Top module: `lsm_seq`

## Requirements
- R1: A command starting at register s (0..31) performs exactly 32 - s word transfers, on registers s, s+1, ..., 31 in ascending order.
- R2: Transfer k (counting from 0) uses byte address base + 4*k, and every issued address has its two low bits zero.
- R3: On a load, a register write (`rf_wr_en`) happens only in a cycle where `mem_rvld` is high. It writes {32'h0, `mem_rdata`} into the register of the current transfer.
- R4: On a store, `mem_we` is 1 and `mem_wdata` equals bits [31:0] of the register being stored. On a load, `mem_we` is 0.
- R5: While `mem_req` is high and `mem_rdy` is low, the request stays asserted with an unchanged address. The sequencer moves to the next word only after a cycle with both `mem_req` and `mem_rdy` high.
- R6: `busy` is high from the cycle after a command is accepted until the last word completes. `done` is high for exactly one cycle, the cycle right after the last word completes, and `busy` is low in that cycle.
- R7: A `start_vld` that arrives while `busy` is high is ignored. The ongoing transfer order, addresses and data do not change, and `align_err` stays low.
- R8: A command accepted while idle whose base address has its low two bits nonzero gives `align_err` high for exactly one cycle, in the following cycle. It raises neither `busy`, `mem_req` nor `done`.
- R9: After reset, `busy`, `done`, `align_err`, `mem_req` and `rf_wr_en` are all low.
- R10: A command presented in the same cycle that `done` is high is accepted, and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Command strobe, taken only when idle |
| start_store | input | 1 | 1 = store registers to memory, 0 = load |
| start_reg | input | 5 | First register of the run |
| start_addr | input | 32 | Base byte address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misaligned-base pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| mem_rvld | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 64 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 64 | Zero-extended loaded word |

## Verification
Two events can land in the same cycle: the completion pulse of one command and the acceptance of the next. The bench drives a new command in exactly the cycle it expects `done`, and it checks that `done` is seen with `busy` low and that `busy` comes back the next cycle with the second command's first address. The opposite case is a command that arrives while a transfer is still running. The bench drives a misaligned command with a different register in the middle of a transfer under memory stalls, and it confirms that every later address, index and data value still follows the first command and that no error pulse appears.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       store;
        logic       done;
        logic       aerr;
    } seq_regs_t;

endpackage

// File: rtl/lsm_cursor.sv
module lsm_cursor #(
    parameter int IDX_W    = 5,
    parameter int ADDR_W   = 32,
    parameter int STEP     = 4,
    parameter int LAST_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [IDX_W-1:0]  idx_init,
    input  logic [ADDR_W-1:0] addr_init,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              is_last
);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } cursor_t;

    cursor_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (load) begin
            cur_d.idx  = idx_init;
            cur_d.addr = addr_init;
        end else if (advance) begin
            cur_d.idx  = cur_q.idx + IDX_W'(1);
            cur_d.addr = cur_q.addr + ADDR_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign idx     = cur_q.idx;
    assign addr    = cur_q.addr;
    assign is_last = (cur_q.idx == IDX_W'(LAST_IDX));

    // R2: each step moves the address by one word
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> addr == $past(addr) + ADDR_W'(STEP));

    // R1: register index climbs by one per step
    a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> idx == $past(idx) + IDX_W'(1));

    // R5: no movement without a step or a reload
    a_r5_cursor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(idx) && $stable(addr)));

endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
    import lsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_vld,
    input  logic start_store,
    input  logic start_misaligned,
    input  logic mem_rdy,
    input  logic mem_rvld,
    input  logic is_last,
    output logic busy,
    output logic done,
    output logic align_err,
    output logic mem_req,
    output logic mem_we,
    output logic rf_wr_en,
    output logic cur_load,
    output logic cur_advance
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.aerr  = 1'b0;
        cur_load    = 1'b0;
        cur_advance = 1'b0;
        mem_req     = 1'b0;
        rf_wr_en    = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start_vld) begin
                    if (start_misaligned) begin
                        seq_d.aerr = 1'b1;
                    end else begin
                        seq_d.state = SEQ_ISSUE;
                        seq_d.store = start_store;
                        cur_load    = 1'b1;
                    end
                end
            end
            SEQ_ISSUE: begin
                mem_req = 1'b1;
                if (mem_rdy) begin
                    if (seq_q.store) begin
                        if (is_last) begin
                            seq_d.state = SEQ_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            cur_advance = 1'b1;
                        end
                    end else begin
                        seq_d.state = SEQ_WAIT;
                    end
                end
            end
            SEQ_WAIT: begin
                if (mem_rvld) begin
                    rf_wr_en = 1'b1;
                    if (is_last) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.state = SEQ_ISSUE;
                        cur_advance = 1'b1;
                    end
                end
            end
            default: begin
                seq_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, store: 1'b0, done: 1'b0, aerr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != SEQ_IDLE);
    assign done      = seq_q.done;
    assign align_err = seq_q.aerr;
    assign mem_we    = mem_req & seq_q.store;

    // R8: a misaligned command from idle yields an error and stays idle
    a_r8_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vld && !busy && start_misaligned) |=> (align_err && !busy));

    // R7: commands during a transfer never raise the error
    a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_vld) |=> !align_err);

    // R6: completion is a single-cycle pulse seen while idle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 64,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_vld,
    input  logic                        start_store,
    input  logic [$clog2(NUM_REGS)-1:0] start_reg,
    input  logic [ADDR_W-1:0]           start_addr,
    output logic                        busy,
    output logic                        done,
    output logic                        align_err,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    input  logic                        mem_rdy,
    input  logic                        mem_rvld,
    input  logic [WORD_W-1:0]           mem_rdata,
    output logic [$clog2(NUM_REGS)-1:0] rf_rd_idx,
    input  logic [REG_W-1:0]            rf_rd_data,
    output logic                        rf_wr_en,
    output logic [$clog2(NUM_REGS)-1:0] rf_wr_idx,
    output logic [REG_W-1:0]            rf_wr_data
);

    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam int PAD_W      = REG_W - WORD_W;

    logic              misaligned;
    logic              cur_load;
    logic              cur_advance;
    logic              is_last;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic              unused_rd_hi;

    assign misaligned = |start_addr[ALIGN_BITS-1:0];

    lsm_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_vld        (start_vld),
        .start_store      (start_store),
        .start_misaligned (misaligned),
        .mem_rdy          (mem_rdy),
        .mem_rvld         (mem_rvld),
        .is_last          (is_last),
        .busy             (busy),
        .done             (done),
        .align_err        (align_err),
        .mem_req          (mem_req),
        .mem_we           (mem_we),
        .rf_wr_en         (rf_wr_en),
        .cur_load         (cur_load),
        .cur_advance      (cur_advance)
    );

    lsm_cursor #(
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .STEP     (WORD_BYTES),
        .LAST_IDX (NUM_REGS - 1)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cur_load),
        .advance   (cur_advance),
        .idx_init  (start_reg),
        .addr_init (start_addr),
        .idx       (cur_idx),
        .addr      (cur_addr),
        .is_last   (is_last)
    );

    assign mem_addr     = cur_addr;
    assign rf_rd_idx    = cur_idx;
    assign mem_wdata    = rf_rd_data[WORD_W-1:0];
    assign rf_wr_idx    = cur_idx;
    assign rf_wr_data   = {{PAD_W{1'b0}}, mem_rdata};
    assign unused_rd_hi = ^rf_rd_data[REG_W-1:WORD_W];

    // R2: issued addresses are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

    // R5: a refused request is held unchanged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: register writes only follow returned read data
    a_r3_write_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (mem_rvld && busy && !mem_req));

    // R9: requests only while a command runs
    a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_vld = 1'b0;
    logic        start_store = 1'b0;
    logic [4:0]  start_reg = '0;
    logic [31:0] start_addr = '0;
    logic        busy, done, align_err, mem_req, mem_we, rf_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rdy = 1'b0;
    logic        mem_rvld = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_rd_idx, rf_wr_idx;
    logic [63:0] rf_rd_data, rf_wr_data;

    logic [63:0] rf_m [0:31];
    logic [31:0] mem_m [0:255];

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit pend = 1'b0;
    logic [31:0] pend_data = '0;
    bit chain = 1'b0;
    bit nx_store = 1'b0;
    logic [4:0] nx_reg = '0;
    logic [31:0] nx_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rf_rd_data = rf_m[rf_rd_idx];

    lsm_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_vld   (start_vld),
        .start_store (start_store),
        .start_reg   (start_reg),
        .start_addr  (start_addr),
        .busy        (busy),
        .done        (done),
        .align_err   (align_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdy     (mem_rdy),
        .mem_rvld    (mem_rvld),
        .mem_rdata   (mem_rdata),
        .rf_rd_idx   (rf_rd_idx),
        .rf_rd_data  (rf_rd_data),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic run_op(input bit st, input logic [4:0] sreg, input logic [31:0] base,
                          input int mode, input bit pre, input bit inject);
        int n = 32 - int'(sreg);
        int k_acc = 0;
        int k_wr = 0;
        int guard = 0;
        bit exp_done = 1'b0;
        bit stalled = 1'b0;
        bit finished = 1'b0;
        bit first = 1'b1;
        logic [31:0] st_addr = '0;
        if (!pre) begin
            @(negedge clk);
            cyc++;
            start_vld = 1'b1; start_store = st; start_reg = sreg; start_addr = base;
            mem_rdy = 1'b0; mem_rvld = 1'b0;
            #1;
            chk(!busy && !mem_req, "R6 idle when command presented", {62'h0, busy, mem_req}, 64'h0);
        end
        while (!finished && guard < 1000) begin
            guard++;
            @(negedge clk);
            cyc++;
            start_vld = 1'b0;
            if (exp_done && chain) begin
                start_vld = 1'b1; start_store = nx_store; start_reg = nx_reg; start_addr = nx_addr;
            end else if (inject && k_acc == 2) begin
                start_vld = 1'b1; start_store = !st; start_reg = 5'd3; start_addr = 32'h2;
            end
            mem_rdy   = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            mem_rvld  = pend && ((mode == 0) || ((cyc % 2) == 0));
            mem_rdata = pend ? pend_data : 32'h0BAD_F00D;
            #1;
            if (first) begin
                chk(busy == 1'b1, "R6 busy after accept", {63'h0, busy}, 64'h1);
                chk(done == 1'b0, "R6 done lasts one cycle", {63'h0, done}, 64'h0);
                first = 1'b0;
            end
            chk(align_err == 1'b0, "R7 no error during transfer", {63'h0, align_err}, 64'h0);
            if (stalled) begin
                chk(mem_req && mem_addr == st_addr, "R5 refused request held",
                    {mem_req, 31'h0, mem_addr}, {1'b1, 31'h0, st_addr});
            end
            stalled = mem_req && !mem_rdy;
            st_addr = mem_addr;
            if (exp_done) begin
                chk(done && !busy && !mem_req, "R6 done after last word",
                    {61'h0, done, busy, mem_req}, 64'h4);
                finished = 1'b1;
            end else begin
                chk(done == 1'b0, "R6 no early done", {63'h0, done}, 64'h0);
                if (mem_req && mem_rdy) begin
                    chk(mem_addr == base + 32'(4 * k_acc), "R2 word address",
                        {32'h0, mem_addr}, {32'h0, base + 32'(4 * k_acc)});
                    chk(mem_we == st, "R4 access direction", {63'h0, mem_we}, {63'h0, st});
                    if (st) begin
                        chk(mem_wdata == rf_m[int'(sreg) + k_acc][31:0], "R4 store low word",
                            {32'h0, mem_wdata}, {32'h0, rf_m[int'(sreg) + k_acc][31:0]});
                        mem_m[mem_addr[9:2]] = mem_wdata;
                        if (k_acc == n - 1) exp_done = 1'b1;
                    end else begin
                        pend = 1'b1;
                        pend_data = mem_m[mem_addr[9:2]];
                    end
                    k_acc++;
                end
                if (rf_wr_en) begin
                    chk(!st && mem_rvld, "R3 write only with valid data",
                        {62'h0, st, mem_rvld}, 64'h1);
                    chk(int'(rf_wr_idx) == int'(sreg) + k_wr, "R1 ascending register",
                        {59'h0, rf_wr_idx}, 64'(int'(sreg) + k_wr));
                    chk(rf_wr_data == {32'h0, pend_data}, "R3 zero-extended word",
                        rf_wr_data, {32'h0, pend_data});
                    rf_m[rf_wr_idx] = rf_wr_data;
                    pend = 1'b0;
                    if (k_wr == n - 1) exp_done = 1'b1;
                    k_wr++;
                end
            end
        end
        chk(k_acc == n, "R1 word count", 64'(k_acc), 64'(n));
        if (!st) chk(k_wr == n, "R1 register write count", 64'(k_wr), 64'(n));
    endtask

    task automatic run_misaligned(input logic [31:0] addr);
        @(negedge clk);
        cyc++;
        start_vld = 1'b1; start_store = addr[0]; start_reg = 5'd10; start_addr = addr;
        mem_rdy = 1'b1; mem_rvld = 1'b0;
        #1;
        chk(!align_err, "R8 error is registered", {63'h0, align_err}, 64'h0);
        @(negedge clk);
        cyc++;
        start_vld = 1'b0;
        #1;
        chk(align_err && !busy && !mem_req && !done, "R8 error pulse, nothing started",
            {60'h0, align_err, busy, mem_req, done}, 64'h8);
        @(negedge clk);
        cyc++;
        #1;
        chk(!align_err && !busy && !mem_req && !done, "R8 error lasts one cycle",
            {60'h0, align_err, busy, mem_req, done}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = (32'(i) * 32'h9E37_79B1) ^ 32'hA5A5_0000;
        for (int i = 0; i < 32; i++) rf_m[i] = {32'hDEAD_0000 | 32'(i), 32'(i) * 32'h0101_0101 + 32'd7};
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !align_err && !mem_req && !rf_wr_en, "R9 reset state",
            {59'h0, busy, done, align_err, mem_req, rf_wr_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !done && !align_err && !mem_req && !rf_wr_en, "R9 idle after reset",
            {59'h0, busy, done, align_err, mem_req, rf_wr_en}, 64'h0);

        for (int mode = 0; mode < 2; mode++) begin
            for (int st = 0; st < 2; st++) begin
                for (int s = 0; s < 32; s++) begin
                    run_op(st[0], 5'(s), 32'h100 + 32'(4 * s) + 32'(mode * 32'h200), mode, 1'b0, 1'b0);
                end
            end
        end

        // R7: commands during a running transfer
        run_op(1'b1, 5'd8, 32'h40, 1, 1'b0, 1'b1);
        run_op(1'b0, 5'd16, 32'h80, 0, 1'b0, 1'b1);
        run_op(1'b0, 5'd20, 32'h300, 1, 1'b0, 1'b1);

        // R8: every misaligned offset
        run_misaligned(32'h101);
        run_misaligned(32'h102);
        run_misaligned(32'h103);

        // R10: next command presented in the done cycle
        chain = 1'b1; nx_store = 1'b1; nx_reg = 5'd30; nx_addr = 32'h20;
        run_op(1'b0, 5'd28, 32'h10, 1, 1'b0, 1'b0);
        chain = 1'b0;
        run_op(1'b1, 5'd30, 32'h20, 1, 1'b1, 1'b0);
        chain = 1'b1; nx_store = 1'b0; nx_reg = 5'd31; nx_addr = 32'h3F0;
        run_op(1'b1, 5'd29, 32'h60, 0, 1'b0, 1'b0);
        chain = 1'b0;
        run_op(1'b0, 5'd31, 32'h3F0, 0, 1'b1, 1'b0);

        @(negedge clk);
        #1;
        chk(!busy && !done, "R10 chained run finished", {62'h0, busy, done}, 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule